// File: doc/BRIEF.md
# Load/Store Byte-Lane Unit

This block sits between a 32-bit integer pipeline and a data memory that is one word wide. It places narrow stores on the correct byte lanes of the memory word. For loads, it picks the correct bytes out of the word the memory returns and widens them to a full register.

For a store, the pipeline presents the effective address, the store data and the 3-bit access-width code in a single cycle. The unit drives the following in the same cycle:

- the word index;
- a byte-enable mask, one bit per lane;
- write data with the narrow value copied onto every lane.

For a load, the unit raises a read strobe in the request cycle and keeps the width code and the low address bits. The memory answers one clock later. The unit then selects the addressed byte or halfword and extends it with sign or zeros, as the width code demands.

The unit does not compute addresses, raise misalignment traps or split accesses that cross a word boundary. It responds only to the load opcode `0000011` and the store opcode `0100011`.

Top module: `byte_lane_unit`

## Requirements
- R1: While reset is applied and in the first cycle after it, with no request presented, `load_valid` is 0 and `load_data` is 0.
- R2: `mem_addr` always equals `req_addr` shifted right by two, which is the word index.
- R3: A store with width code 000 enables only lane `req_addr[1:0]` (mask `0001 << req_addr[1:0]`, where lane k is bits 8k+7:8k). It drives `req_wdata[7:0]` on all four lanes.
- R4: A store with width code 001 enables mask `0011` when `req_addr[1]` is 0 and mask `1100` when `req_addr[1]` is 1, ignoring `req_addr[0]`. It drives `req_wdata[15:0]` on both halves.
- R5: A store with width code 010 enables mask `1111` and drives `req_wdata` unchanged.
- R6: A store with any other width code drives mask `0000` and write data 0.
- R7: The following hold:
    - The mask is nonzero only when `req_valid` is 1 and `req_opcode` is `0100011`.
    - `mem_re` is 1 exactly when `req_valid` is 1 and `req_opcode` is `0000011`.
    - In every cycle without a valid store, `mem_wdata` is 0 and the mask is 0.
    - `mem_re` and a nonzero mask never occur together.
- R8: The load response timing is as follows:
    - `load_valid` is 1 in the cycle after a cycle with `mem_re`, and 0 otherwise.
    - The result is built from `mem_rdata` of that later cycle, using the width code and address bits of the request cycle. Back-to-back loads therefore each use their own width code and address bits.
    - `load_data` is 0 whenever `load_valid` is 0.
- R9: Load width code 000 returns byte lane `addr[1:0]`, sign-extended to 32 bits.
- R10: Load width code 001 returns bits 15:0 when `addr[1]` is 0 and bits 31:16 when `addr[1]` is 1, sign-extended.
- R11: Load width code 010 returns the memory word unchanged.
- R12: Load width code 100 returns the addressed byte zero-extended, and width code 101 returns the addressed halfword (chosen as in R10) zero-extended.
- R13: Load width codes 011, 110 and 111 return 0, while `load_valid` is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A request is presented this cycle |
| req_opcode | input | 7 | Major opcode of the instruction |
| req_funct3 | input | 3 | Access width and extension code |
| req_addr | input | 32 | Effective byte address |
| req_wdata | input | 32 | Store data from the register file |
| mem_addr | output | 30 | Word index into the data memory |
| mem_be | output | 4 | Per-lane write enables |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_re | output | 1 | Read strobe for a load |
| mem_rdata | input | 32 | Word returned one clock after `mem_re` |
| load_valid | output | 1 | Load result is valid this cycle |
| load_data | output | 32 | Extended load result |

## Verification
Some properties are checked by assertions on every cycle:

- the lane count of the mask for each store width matches the width;
- a nonzero mask appears only with a store opcode, and never together with a read;
- the one-cycle link between `mem_re` and `load_valid`;
- a zero result while no load is valid;
- the sign and zero fill of the upper bits for byte and halfword loads.

The assertions cannot show which lane was chosen, that the replicated data is right, or that a result uses the width code and offset of its own request. Only the bench's directed sweeps over every width code and offset, and its random back-to-back traffic compared against computed values, show these.

// File: rtl/lane_unit_pkg.sv
// Shared constants and the width-code encoding for the byte-lane unit.
package lane_unit_pkg;

    localparam logic [6:0] OPC_LOAD  = 7'b0000011;
    localparam logic [6:0] OPC_STORE = 7'b0100011;

    // Width/extension code carried in the funct3 field of loads and stores.
    typedef enum logic [2:0] {
        WC_BYTE  = 3'b000,
        WC_HALF  = 3'b001,
        WC_WORD  = 3'b010,
        WC_RSV3  = 3'b011,
        WC_UBYTE = 3'b100,
        WC_UHALF = 3'b101,
        WC_RSV6  = 3'b110,
        WC_RSV7  = 3'b111
    } width_code_e;

endpackage

// File: rtl/lane_store_steer.sv
// Store steering: turns a width code and byte offset into a lane-enable mask
// and copies the narrow store value onto every lane.
// Assumes halfwords are aligned; offset bit 0 is ignored for halfwords.
// Purely combinational; produces zeros when en is low or the code is unused.
module lane_store_steer
    import lane_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic              en,
    input  logic [2:0]        funct3,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    output logic [LANES-1:0]  be,
    output logic [DATA_W-1:0] wdata_rep
);

    logic [LANES-1:0]  byte_hit;
    logic [LANES-1:0]  half_hit;
    logic [DATA_W-1:0] byte_rep;
    logic [DATA_W-1:0] half_rep;

    // Per-lane hit decode and replication of the narrow value.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign byte_hit[g]        = (off == OFF_W'(g));
        assign half_hit[g]        = (off[OFF_W-1:1] == (OFF_W-1)'(g / 2));
        assign byte_rep[g*8 +: 8] = wdata[7:0];
        assign half_rep[g*8 +: 8] = wdata[(g % 2)*8 +: 8];
    end

    // Select mask and data by width code; unused codes and idle give zeros.
    always_comb begin
        be        = '0;
        wdata_rep = '0;
        if (en) begin
            case (width_code_e'(funct3))
                WC_BYTE: begin be = byte_hit;  wdata_rep = byte_rep; end
                WC_HALF: begin be = half_hit;  wdata_rep = half_rep; end
                WC_WORD: begin be = '1;        wdata_rep = wdata;    end
                default: begin be = '0;        wdata_rep = '0;       end
            endcase
        end
    end

    // Lane count of the mask matches the requested width.
    always_comb begin
        if (en && funct3 == WC_BYTE)
            a_r3_byte_one_lane: assert ($countones(be) == 1);
        if (en && funct3 == WC_HALF)
            a_r4_half_two_lanes: assert ($countones(be) == 2);
        if (en && funct3 == WC_WORD)
            a_r5_word_all_lanes: assert (be == '1);
    end

endmodule

// File: rtl/lane_load_extract.sv
// Load extraction: picks the addressed byte or halfword from the returned
// memory word and sign- or zero-extends it according to the width code.
// Assumes code and offset are those of the request one cycle earlier.
// Purely combinational; output is zero when valid is low or the code is unused.
module lane_load_extract
    import lane_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic              valid,
    input  logic [2:0]        funct3,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] data
);

    logic [7:0]       lane_bytes [LANES];
    logic [OFF_W-1:0] half_lo_idx;
    logic [OFF_W-1:0] half_hi_idx;
    logic [7:0]       sel_byte;
    logic [15:0]      sel_half;

    // Split the returned word into byte lanes.
    for (genvar g = 0; g < LANES; g++) begin : g_split
        assign lane_bytes[g] = rdata[g*8 +: 8];
    end

    assign half_lo_idx = {off[OFF_W-1:1], 1'b0};
    assign half_hi_idx = {off[OFF_W-1:1], 1'b1};
    assign sel_byte    = lane_bytes[off];
    assign sel_half    = {lane_bytes[half_hi_idx], lane_bytes[half_lo_idx]};

    // Extend the selected piece by width code; unused codes give zero.
    always_comb begin
        data = '0;
        if (valid) begin
            case (width_code_e'(funct3))
                WC_BYTE:  data = {{(DATA_W-8){sel_byte[7]}}, sel_byte};
                WC_HALF:  data = {{(DATA_W-16){sel_half[15]}}, sel_half};
                WC_WORD:  data = rdata;
                WC_UBYTE: data = {{(DATA_W-8){1'b0}}, sel_byte};
                WC_UHALF: data = {{(DATA_W-16){1'b0}}, sel_half};
                default:  data = '0;
            endcase
        end
    end

    // Upper-bit fill follows the extension kind.
    always_comb begin
        if (valid && funct3 == WC_BYTE)
            a_r9_byte_sign_fill: assert (data[DATA_W-1:8] == {(DATA_W-8){data[7]}});
        if (valid && funct3 == WC_HALF)
            a_r10_half_sign_fill: assert (data[DATA_W-1:16] == {(DATA_W-16){data[15]}});
        if (valid && (funct3 == WC_UBYTE))
            a_r12_ubyte_zero_fill: assert (data[DATA_W-1:8] == '0);
        if (valid && (funct3 == WC_UHALF))
            a_r12_uhalf_zero_fill: assert (data[DATA_W-1:16] == '0);
    end

endmodule

// File: rtl/lane_load_track.sv
// Load tracking register: remembers that a read was issued, together with its
// width code and byte offset, so they line up with data one clock later.
// Assumes fixed one-cycle memory read latency. Synchronous active-low reset.
module lane_load_track #(
    parameter int OFF_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic [2:0]       funct3,
    input  logic [OFF_W-1:0] off,
    output logic             pend,
    output logic [2:0]       funct3_q,
    output logic [OFF_W-1:0] off_q
);

    // Mark a pending response for exactly one cycle after each read.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= 1'b0;
        else        pend <= capture;
    end

    // Hold the request's code and offset for the response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            funct3_q <= '0;
            off_q    <= '0;
        end else if (capture) begin
            funct3_q <= funct3;
            off_q    <= off;
        end
    end

endmodule

// File: rtl/byte_lane_unit.sv
// Byte-lane unit between an integer pipeline and a word-wide data memory.
// Stores are steered in the request cycle; loads are extracted one clock
// later from the returned word. Assumes aligned halfwords and no accesses
// that span words. Synchronous active-low reset.
module byte_lane_unit
    import lane_unit_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int LANES  = DATA_W / 8,
    parameter int OFF_W  = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic [6:0]              req_opcode,
    input  logic [2:0]              req_funct3,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [DATA_W-1:0]       req_wdata,
    output logic [ADDR_W-OFF_W-1:0] mem_addr,
    output logic [LANES-1:0]        mem_be,
    output logic [DATA_W-1:0]       mem_wdata,
    output logic                    mem_re,
    input  logic [DATA_W-1:0]       mem_rdata,
    output logic                    load_valid,
    output logic [DATA_W-1:0]       load_data
);

    logic             is_store;
    logic [2:0]       pend_funct3;
    logic [OFF_W-1:0] pend_off;

    // Opcode decode gated by the request strobe.
    assign is_store = req_valid && (req_opcode == OPC_STORE);
    assign mem_re   = req_valid && (req_opcode == OPC_LOAD);
    assign mem_addr = req_addr[ADDR_W-1:OFF_W];

    lane_store_steer #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_steer (
        .en        (is_store),
        .funct3    (req_funct3),
        .off       (req_addr[OFF_W-1:0]),
        .wdata     (req_wdata),
        .be        (mem_be),
        .wdata_rep (mem_wdata)
    );

    lane_load_track #(.OFF_W(OFF_W)) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .capture  (mem_re),
        .funct3   (req_funct3),
        .off      (req_addr[OFF_W-1:0]),
        .pend     (load_valid),
        .funct3_q (pend_funct3),
        .off_q    (pend_off)
    );

    lane_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFF_W(OFF_W)) u_extract (
        .valid  (load_valid),
        .funct3 (pend_funct3),
        .off    (pend_off),
        .rdata  (mem_rdata),
        .data   (load_data)
    );

    // R7: write enables only under a presented store.
    a_r7_be_needs_store: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_be != '0) |-> (req_valid && req_opcode == OPC_STORE));
    // R7: a read and a write never share a cycle.
    a_r7_read_write_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |-> (mem_be == '0));
    // R8: every read is answered in the next cycle.
    a_r8_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> load_valid);
    // R8: no response without a read in the cycle before.
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_re |=> !load_valid);
    // R8: result is quiet when no load completes.
    a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !load_valid |-> (load_data == '0));

endmodule

// File: tb/byte_lane_unit_tb.sv
module byte_lane_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] OP_LD = 7'b0000011;
    localparam logic [6:0] OP_ST = 7'b0100011;
    localparam logic [6:0] OP_AL = 7'b0110011;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [6:0]  req_opcode = '0;
    logic [2:0]  req_funct3 = '0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [29:0] mem_addr;
    logic [3:0]  mem_be;
    logic [31:0] mem_wdata;
    logic        mem_re;
    logic [31:0] mem_rdata = '0;
    logic        load_valid;
    logic [31:0] load_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    bit          prev_rd  = 0;
    logic [2:0]  prev_f3  = '0;
    logic [1:0]  prev_off = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    byte_lane_unit u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_opcode(req_opcode),
        .req_funct3(req_funct3), .req_addr(req_addr), .req_wdata(req_wdata),
        .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_re(mem_re),
        .mem_rdata(mem_rdata), .load_valid(load_valid), .load_data(load_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_be(input logic [2:0] f3, input logic [1:0] off);
        case (f3)
            3'b000:  return 4'b0001 << off;
            3'b001:  return off[1] ? 4'b1100 : 4'b0011;
            3'b010:  return 4'b1111;
            default: return 4'b0000;
        endcase
    endfunction

    function automatic logic [31:0] exp_wd(input logic [2:0] f3, input logic [31:0] d);
        case (f3)
            3'b000:  return {4{d[7:0]}};
            3'b001:  return {2{d[15:0]}};
            3'b010:  return d;
            default: return 32'h0;
        endcase
    endfunction

    function automatic logic [31:0] exp_ld(input logic [2:0] f3, input logic [1:0] off, input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        b = w >> (off * 8);
        h = off[1] ? w[31:16] : w[15:0];
        case (f3)
            3'b000:  return {{24{b[7]}}, b};
            3'b001:  return {{16{h[15]}}, h};
            3'b010:  return w;
            3'b100:  return {24'h0, b};
            3'b101:  return {16'h0, h};
            default: return 32'h0;
        endcase
    endfunction

    function automatic string st_tag(input logic [2:0] f3);
        case (f3)
            3'b000:  return "R3";
            3'b001:  return "R4";
            3'b010:  return "R5";
            default: return "R6";
        endcase
    endfunction

    function automatic string ld_tag(input logic [2:0] f3);
        case (f3)
            3'b000:  return "R9";
            3'b001:  return "R10";
            3'b010:  return "R11";
            3'b100, 3'b101: return "R12";
            default: return "R13";
        endcase
    endfunction

    // One cycle: drive a request and the response word for the previous read,
    // then check the combinational store outputs and the pending load result.
    task automatic step(input bit v, input logic [6:0] opc, input logic [2:0] f3,
                        input logic [31:0] addr, input logic [31:0] wd, input logic [31:0] rd);
        bit st;
        bit ld;
        @(negedge clk);
        req_valid = v; req_opcode = opc; req_funct3 = f3;
        req_addr = addr; req_wdata = wd; mem_rdata = rd;
        #1;
        st = v && (opc == OP_ST);
        ld = v && (opc == OP_LD);
        chk(mem_addr == addr[31:2], "R2", {2'b0, mem_addr}, {2'b0, addr[31:2]});
        if (st) begin
            chk(mem_be == exp_be(f3, addr[1:0]), st_tag(f3), {28'h0, mem_be}, {28'h0, exp_be(f3, addr[1:0])});
            chk(mem_wdata == exp_wd(f3, wd), st_tag(f3), mem_wdata, exp_wd(f3, wd));
        end else begin
            chk(mem_be == 4'b0000, "R7", {28'h0, mem_be}, 32'h0);
            chk(mem_wdata == 32'h0, "R7", mem_wdata, 32'h0);
        end
        chk(mem_re == ld, "R7", {31'h0, mem_re}, {31'h0, ld});
        chk(load_valid == prev_rd, "R8", {31'h0, load_valid}, {31'h0, prev_rd});
        if (prev_rd)
            chk(load_data == exp_ld(prev_f3, prev_off, rd), ld_tag(prev_f3), load_data, exp_ld(prev_f3, prev_off, rd));
        else
            chk(load_data == 32'h0, "R8", load_data, 32'h0);
        prev_rd  = ld;
        prev_f3  = f3;
        prev_off = addr[1:0];
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'd1234);
        repeat (3) @(negedge clk);
        #1;
        chk(load_valid == 1'b0, "R1", {31'h0, load_valid}, 32'h0);
        chk(load_data == 32'h0, "R1", load_data, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(load_valid == 1'b0, "R1", {31'h0, load_valid}, 32'h0);
        chk(load_data == 32'h0, "R1", load_data, 32'h0);

        // Directed: every width code at every offset, stores then loads back to back.
        for (int f = 0; f < 8; f++)
            for (int o = 0; o < 4; o++)
                step(1'b1, OP_ST, 3'(f), 32'h0000_1000 + 32'(o), 32'hA5C3_817E, 32'h0);
        for (int f = 0; f < 8; f++)
            for (int o = 0; o < 4; o++)
                step(1'b1, OP_LD, 3'(f), 32'h0000_2000 + 32'(o), 32'h0, 32'h80FF_7F01 ^ 32'(f << 8));
        step(1'b0, OP_AL, 3'b000, 32'h0, 32'h0, 32'hF08F_8001);
        // Directed: non-memory opcode and valid-low requests are ignored (R7).
        step(1'b1, OP_AL, 3'b010, 32'h0000_3000, 32'hFFFF_FFFF, 32'h0);
        step(1'b0, OP_ST, 3'b010, 32'h0000_3004, 32'hFFFF_FFFF, 32'h1234_5678);
        step(1'b0, OP_LD, 3'b010, 32'h0000_3008, 32'h0, 32'h1234_5678);
        step(1'b0, OP_AL, 3'b000, 32'h0, 32'h0, 32'hDEAD_BEEF);

        // Random mixed traffic.
        for (int i = 0; i < 600; i++) begin
            logic [6:0] opc;
            int sel;
            sel = $urandom % 5;
            opc = (sel < 2) ? OP_LD : (sel < 4) ? OP_ST : OP_AL;
            step(($urandom % 8) != 0, opc, 3'($urandom), $urandom, $urandom, $urandom);
        end
        step(1'b0, OP_AL, 3'b000, 32'h0, 32'h0, $urandom);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule